// File: doc/BRIEF.md
# SDRAM Command Legality Checker

The block sits beside the command bus of a two-bank or four-bank SDRAM and judges each command as it goes past. It keeps a model of every bank (idle, active with a page open, or precharging) and of the device's low-power state. From that model and a set of programmable minimum intervals it decides whether the command is legal. A verdict appears one cycle after the command. The block does not issue commands and does not touch the data path. Its only data-related output asks the write path to mask data beats that have not yet had time to be written when a precharge closes their page.

Legality depends on the bank that the bank address selects. An activate can be legal for an idle bank and illegal in the same cycle for a bank that already has a page open. CKE is taken into account as well. When every live bank is idle and CKE is low, the device is classed as powered down, or as self-refreshing if a self-refresh entry was accepted. An illegal command is only reported: it leaves the model unchanged.

Top module: `sdram_cmd_guard`

## Requirements
- R1: While reset is asserted and after it is released, every output is low, every bank is idle and no low-power mode is indicated.
- R2: The command encoding is 0 NOP, 1 activate, 2 read, 3 write, 4 precharge, 5 auto refresh, 6 self-refresh entry, and 7 reserved, which is always illegal. Every command other than NOP raises `verdict_valid_o` in the next cycle, and `illegal_o` gives the result in that same cycle. A NOP gives no verdict.
- R3: Legality is judged against the bank selected by `ba_i`. An activate needs an idle bank. A read or write needs an active bank. A precharge of an idle or precharging bank is legal and has no effect.
- R4: A read or write to a bank that was activated in cycle c is illegal before cycle c+`t_rcd_i`.
- R5: A precharge to a bank that was activated in cycle c is illegal before cycle c+`t_ras_i`.
- R6: After a legal activate in cycle c, any activate before cycle c+`t_rrd_i` is illegal.
- R7: A bank precharged in cycle c stays precharging, so an activate to it is illegal, until cycle c+`t_rp_i`. At that cycle the bank is idle again.
- R8: After a legal read or write in cycle c, any read or write before c+`t_ccd_i` is illegal. This is the spacing for interrupting a burst. A write before c+`t_turn_i` after a read in cycle c is illegal, because the bus must turn around.
- R9: A legal precharge of an active bank in cycle p raises `mask_req_o` with its verdict if that bank took a write in cycle w and p < w+`t_dpl_i`.
- R10: Auto refresh is legal only when every live bank is idle.
- R11: In the cycle after an edge at which CKE is low and every live bank is idle, `power_down_o` is high. `self_refresh_o` is high instead when a legal self-refresh entry has been taken and CKE has stayed low since. CKE high clears both after the next edge. The two are never high together.
- R12: Activate, read, write, precharge and auto refresh are illegal when CKE is low or a low-power mode is indicated. Self-refresh entry is legal only with CKE low, every live bank idle and self-refresh not already indicated.
- R13: An illegal command changes no bank state, timer or mode.
- R14: With `four_bank_i` low only banks 0 and 1 are live. A command whose bank address has its top bit set is illegal, and banks 2 and 3 do not count in the all-idle tests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Decoded command, encoding in R2 |
| ba_i | input | BA_W | Bank address |
| cke_i | input | 1 | Clock enable as seen by the device |
| four_bank_i | input | 1 | 1: four live banks, 0: two |
| t_rcd_i | input | T_W | Activate to read/write, cycles (2..15) |
| t_ras_i | input | T_W | Activate to precharge, cycles |
| t_rrd_i | input | T_W | Activate to activate, cycles |
| t_rp_i | input | T_W | Precharge to idle, cycles |
| t_dpl_i | input | T_W | Write recovery window, cycles |
| t_ccd_i | input | T_W | Read/write to read/write, cycles |
| t_turn_i | input | T_W | Read to write turnaround, cycles |
| verdict_valid_o | output | 1 | A verdict is presented this cycle |
| illegal_o | output | 1 | The command judged was illegal |
| mask_req_o | output | 1 | Mask unrecovered write data |
| power_down_o | output | 1 | Power-down mode |
| self_refresh_o | output | 1 | Self-refresh mode |

## Verification
The hardest state to reach is a device that is in self-refresh and has already left power-down. Getting there needs every bank idle, and that takes precharges timed against tRAS and tRP, a legal auto refresh, then CKE dropped for power-down before self-refresh entry is accepted. The table walks that whole sequence, which starts with two banks open and a write that leaves its recovery window open. A directed test then opens an upper bank, switches to two-bank mode and shows that this bank no longer blocks power-down.

// File: rtl/sdram_guard_pkg.sv
`timescale 1ns/1ps
package sdram_guard_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_AREF = 3'd5,
    CMD_SREF = 3'd6,
    CMD_RSV  = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE   = 2'd0,
    BK_ACTIVE = 2'd1,
    BK_PRECH  = 2'd2
  } bank_st_e;

  typedef enum logic [1:0] {
    LP_NONE = 2'd0,
    LP_PDN  = 2'd1,
    LP_SREF = 2'd2
  } lp_e;
endpackage

// File: rtl/sdram_gap_timer.sv
`timescale 1ns/1ps
module sdram_gap_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  output logic         zero_o
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= value_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - ONE;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_bank_track.sv
`timescale 1ns/1ps
module sdram_bank_track
  import sdram_guard_pkg::*;
#(
  parameter int T_W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           act_i,
  input  logic           pre_i,
  input  logic           wr_i,
  input  logic [T_W-1:0] t_rcd_i,
  input  logic [T_W-1:0] t_ras_i,
  input  logic [T_W-1:0] t_rp_i,
  input  logic [T_W-1:0] t_dpl_i,
  output bank_st_e       state_o,
  output logic           rcd_ok_o,
  output logic           ras_ok_o,
  output logic           dpl_open_o
);
  localparam logic [T_W-1:0] ONE = T_W'(1);
  localparam logic [T_W-1:0] TWO = T_W'(2);

  bank_st_e st_q;
  logic     rp_zero, dpl_zero;

  sdram_gap_timer #(.W(T_W)) u_rcd (
    .clk_i, .rst_ni, .load_i(act_i), .value_i(t_rcd_i - ONE), .zero_o(rcd_ok_o));
  sdram_gap_timer #(.W(T_W)) u_ras (
    .clk_i, .rst_ni, .load_i(act_i), .value_i(t_ras_i - ONE), .zero_o(ras_ok_o));
  // precharge ends one edge after count reaches zero
  sdram_gap_timer #(.W(T_W)) u_rp (
    .clk_i, .rst_ni, .load_i(pre_i), .value_i(t_rp_i - TWO), .zero_o(rp_zero));
  sdram_gap_timer #(.W(T_W)) u_dpl (
    .clk_i, .rst_ni, .load_i(wr_i), .value_i(t_dpl_i - ONE), .zero_o(dpl_zero));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= BK_IDLE;
    else begin
      unique case (st_q)
        BK_IDLE:   if (act_i)   st_q <= BK_ACTIVE;
        BK_ACTIVE: if (pre_i)   st_q <= BK_PRECH;
        BK_PRECH:  if (rp_zero) st_q <= BK_IDLE;
        default:                st_q <= BK_IDLE;
      endcase
    end
  end

  assign state_o    = st_q;
  assign dpl_open_o = !dpl_zero;
endmodule

// File: rtl/sdram_cmd_guard.sv
`timescale 1ns/1ps
module sdram_cmd_guard
  import sdram_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_W       = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2:0]      cmd_i,
  input  logic [BA_W-1:0] ba_i,
  input  logic            cke_i,
  input  logic            four_bank_i,
  input  logic [T_W-1:0]  t_rcd_i,
  input  logic [T_W-1:0]  t_ras_i,
  input  logic [T_W-1:0]  t_rrd_i,
  input  logic [T_W-1:0]  t_rp_i,
  input  logic [T_W-1:0]  t_dpl_i,
  input  logic [T_W-1:0]  t_ccd_i,
  input  logic [T_W-1:0]  t_turn_i,
  output logic            verdict_valid_o,
  output logic            illegal_o,
  output logic            mask_req_o,
  output logic            power_down_o,
  output logic            self_refresh_o
);
  localparam logic [T_W-1:0] ONE  = T_W'(1);
  localparam int             HALF = NUM_BANKS / 2;

  cmd_e     cmd;
  bank_st_e bk_st [NUM_BANKS];
  logic [NUM_BANKS-1:0] rcd_ok, ras_ok, dpl_open, bk_live, bk_idle;
  logic [NUM_BANKS-1:0] act_v, pre_v, wr_v;
  lp_e  lp_q, lp_d;
  logic rrd_zero, ccd_zero, turn_zero;
  logic legal, awake, all_idle, bank_ok, sel_active, sel_idle;
  logic act_go, rd_go, wr_go, col_go, pre_go, mask_d;
  logic verdict_q, illegal_q, mask_q;

  assign cmd = cmd_e'(cmd_i);

  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
    assign bk_live[gi] = four_bank_i || (gi < HALF);
    assign bk_idle[gi] = (bk_st[gi] == BK_IDLE);
    assign act_v[gi]   = act_go && (ba_i == BA_W'(gi));
    assign pre_v[gi]   = pre_go && (ba_i == BA_W'(gi));
    assign wr_v[gi]    = wr_go  && (ba_i == BA_W'(gi));

    sdram_bank_track #(.T_W(T_W)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .act_i      (act_v[gi]),
      .pre_i      (pre_v[gi]),
      .wr_i       (wr_v[gi]),
      .t_rcd_i    (t_rcd_i),
      .t_ras_i    (t_ras_i),
      .t_rp_i     (t_rp_i),
      .t_dpl_i    (t_dpl_i),
      .state_o    (bk_st[gi]),
      .rcd_ok_o   (rcd_ok[gi]),
      .ras_ok_o   (ras_ok[gi]),
      .dpl_open_o (dpl_open[gi])
    );
  end

  assign all_idle   = &(bk_idle | ~bk_live);
  assign bank_ok    = bk_live[ba_i];
  assign sel_active = (bk_st[ba_i] == BK_ACTIVE);
  assign sel_idle   = (bk_st[ba_i] == BK_IDLE);
  assign awake      = cke_i && (lp_q == LP_NONE);

  always_comb begin
    unique case (cmd)
      CMD_NOP:  legal = 1'b1;
      CMD_ACT:  legal = awake && bank_ok && sel_idle && rrd_zero;
      CMD_RD:   legal = awake && bank_ok && sel_active && rcd_ok[ba_i] && ccd_zero;
      CMD_WR:   legal = awake && bank_ok && sel_active && rcd_ok[ba_i] && ccd_zero
                        && turn_zero;
      CMD_PRE:  legal = awake && bank_ok && (!sel_active || ras_ok[ba_i]);
      CMD_AREF: legal = awake && all_idle;
      CMD_SREF: legal = !cke_i && all_idle && (lp_q != LP_SREF);
      default:  legal = 1'b0;
    endcase
  end

  assign act_go = legal && (cmd == CMD_ACT);
  assign rd_go  = legal && (cmd == CMD_RD);
  assign wr_go  = legal && (cmd == CMD_WR);
  assign col_go = rd_go || wr_go;
  assign pre_go = legal && (cmd == CMD_PRE) && sel_active;
  assign mask_d = pre_go && dpl_open[ba_i];

  sdram_gap_timer #(.W(T_W)) u_rrd (
    .clk_i, .rst_ni, .load_i(act_go), .value_i(t_rrd_i - ONE), .zero_o(rrd_zero));
  sdram_gap_timer #(.W(T_W)) u_ccd (
    .clk_i, .rst_ni, .load_i(col_go), .value_i(t_ccd_i - ONE), .zero_o(ccd_zero));
  sdram_gap_timer #(.W(T_W)) u_turn (
    .clk_i, .rst_ni, .load_i(rd_go), .value_i(t_turn_i - ONE), .zero_o(turn_zero));

  always_comb begin
    if (!cke_i && all_idle)
      lp_d = (lp_q == LP_SREF || (legal && cmd == CMD_SREF)) ? LP_SREF : LP_PDN;
    else
      lp_d = LP_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lp_q      <= LP_NONE;
      verdict_q <= 1'b0;
      illegal_q <= 1'b0;
      mask_q    <= 1'b0;
    end else begin
      lp_q      <= lp_d;
      verdict_q <= (cmd != CMD_NOP);
      illegal_q <= !legal;
      mask_q    <= mask_d;
    end
  end

  assign verdict_valid_o = verdict_q;
  assign illegal_o       = illegal_q;
  assign mask_req_o      = mask_q;
  assign power_down_o    = (lp_q == LP_PDN);
  assign self_refresh_o  = (lp_q == LP_SREF);
endmodule

// File: rtl/sdram_cmd_guard_chk.sv
`timescale 1ns/1ps
module sdram_cmd_guard_chk
  import sdram_guard_pkg::*;
#(
  parameter int T_W = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [2:0]     cmd_i,
  input logic           cke_i,
  input logic           four_bank_i,
  input logic [T_W-1:0] t_rrd_i,
  input logic           verdict_valid_o,
  input logic           illegal_o,
  input logic           mask_req_o,
  input logic           power_down_o,
  input logic           self_refresh_o
);
  AST_VERDICT_GATES_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> verdict_valid_o); // R2

  AST_MASK_ON_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_req_o |-> (verdict_valid_o && !illegal_o)); // R9

  AST_RRD_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_valid_o && !illegal_o && $past(cmd_i) == CMD_ACT && cmd_i == CMD_ACT
     && t_rrd_i >= T_W'(2)) |=> illegal_o); // R6

  AST_LP_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(power_down_o && self_refresh_o)); // R11

  AST_CKE_WAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i |=> (!power_down_o && !self_refresh_o)); // R11

  AST_SREF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (self_refresh_o && !cke_i) |=> (self_refresh_o || four_bank_i != $past(four_bank_i))); // R11

  AST_LP_BLOCKS_CMDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((power_down_o || self_refresh_o) &&
     (cmd_i == CMD_ACT || cmd_i == CMD_RD || cmd_i == CMD_WR ||
      cmd_i == CMD_PRE || cmd_i == CMD_AREF)) |=> illegal_o); // R12
endmodule

bind sdram_cmd_guard sdram_cmd_guard_chk #(.T_W(T_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cmd_i           (cmd_i),
  .cke_i           (cke_i),
  .four_bank_i     (four_bank_i),
  .t_rrd_i         (t_rrd_i),
  .verdict_valid_o (verdict_valid_o),
  .illegal_o       (illegal_o),
  .mask_req_o      (mask_req_o),
  .power_down_o    (power_down_o),
  .self_refresh_o  (self_refresh_o)
);

// File: tb/sdram_cmd_guard_test.sv
`timescale 1ns/1ps
module sdram_cmd_guard_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [1:0] ba = 2'd0;
  logic       cke = 1'b1;
  logic       four_bank = 1'b1;
  logic       vld, ill, msk, pd, sr;
  int         checks = 0;
  int         errors = 0;

  always #2.5 clk = ~clk;

  sdram_cmd_guard #(.NUM_BANKS(4), .T_W(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .ba_i(ba), .cke_i(cke),
    .four_bank_i(four_bank),
    .t_rcd_i(4'd3), .t_ras_i(4'd5), .t_rrd_i(4'd2), .t_rp_i(4'd3),
    .t_dpl_i(4'd2), .t_ccd_i(4'd2), .t_turn_i(4'd3),
    .verdict_valid_o(vld), .illegal_o(ill), .mask_req_o(msk),
    .power_down_o(pd), .self_refresh_o(sr));

  typedef struct packed {
    logic [2:0]  c;
    logic [1:0]  b;
    logic        k;
    logic [4:0]  exp;   // {valid, illegal, mask, pd, sr}
    logic [23:0] tag;
  } vec_t;

  // cmd: 0 NOP 1 ACT 2 RD 3 WR 4 PRE 5 AREF 6 SREF 7 reserved
  localparam vec_t VECS [34] = '{
    '{3'd0, 2'd0, 1'b1, 5'b00000, "R2 "},  // 0  nop, no verdict
    '{3'd1, 2'd0, 1'b1, 5'b10000, "R3 "},  // 1  act b0
    '{3'd1, 2'd1, 1'b1, 5'b11000, "R6 "},  // 2  act b1 inside trrd
    '{3'd1, 2'd1, 1'b1, 5'b10000, "R13"},  // 3  b1 untouched by illegal act
    '{3'd2, 2'd1, 1'b1, 5'b11000, "R4 "},  // 4  rd b1 inside trcd
    '{3'd2, 2'd0, 1'b1, 5'b10000, "R4 "},  // 5  rd b0 after trcd
    '{3'd2, 2'd0, 1'b1, 5'b11000, "R8 "},  // 6  rd inside tccd
    '{3'd3, 2'd0, 1'b1, 5'b11000, "R8 "},  // 7  wr inside turnaround
    '{3'd3, 2'd1, 1'b1, 5'b10000, "R8 "},  // 8  wr b1 legal
    '{3'd4, 2'd1, 1'b1, 5'b10100, "R9 "},  // 9  pre b1 inside tdpl -> mask
    '{3'd4, 2'd0, 1'b1, 5'b10000, "R9 "},  // 10 pre b0, no write -> no mask
    '{3'd1, 2'd1, 1'b1, 5'b11000, "R7 "},  // 11 act b1 still precharging
    '{3'd1, 2'd1, 1'b1, 5'b10000, "R7 "},  // 12 act b1 after trp
    '{3'd4, 2'd1, 1'b1, 5'b11000, "R5 "},  // 13 pre b1 inside tras
    '{3'd5, 2'd0, 1'b1, 5'b11000, "R10"},  // 14 aref with b1 open
    '{3'd1, 2'd2, 1'b1, 5'b10000, "R3 "},  // 15 act b2
    '{3'd0, 2'd0, 1'b1, 5'b00000, "R2 "},  // 16
    '{3'd1, 2'd1, 1'b1, 5'b11000, "R3 "},  // 17 act b1 already open
    '{3'd2, 2'd3, 1'b1, 5'b11000, "R3 "},  // 18 rd idle b3
    '{3'd2, 2'd2, 1'b1, 5'b10000, "R3 "},  // 19 rd open b2
    '{3'd4, 2'd1, 1'b1, 5'b10000, "R5 "},  // 20 pre b1
    '{3'd4, 2'd2, 1'b1, 5'b10000, "R5 "},  // 21 pre b2
    '{3'd0, 2'd0, 1'b1, 5'b00000, "R2 "},  // 22
    '{3'd0, 2'd0, 1'b1, 5'b00000, "R2 "},  // 23
    '{3'd0, 2'd0, 1'b1, 5'b00000, "R2 "},  // 24
    '{3'd5, 2'd0, 1'b1, 5'b10000, "R10"},  // 25 aref all idle
    '{3'd0, 2'd0, 1'b0, 5'b00010, "R11"},  // 26 cke low -> power down
    '{3'd1, 2'd0, 1'b0, 5'b11010, "R12"},  // 27 act in power down
    '{3'd6, 2'd0, 1'b0, 5'b10001, "R11"},  // 28 sref entry
    '{3'd0, 2'd0, 1'b0, 5'b00001, "R11"},  // 29 sref holds
    '{3'd6, 2'd0, 1'b0, 5'b11001, "R12"},  // 30 second sref illegal
    '{3'd0, 2'd0, 1'b1, 5'b00000, "R11"},  // 31 cke high wakes
    '{3'd1, 2'd0, 1'b1, 5'b10000, "R12"},  // 32 act after exit
    '{3'd7, 2'd0, 1'b1, 5'b11000, "R2 "}   // 33 reserved code
  };

  task automatic check(input logic [23:0] tag, input logic [4:0] exp);
    logic [4:0] got;
    got = {vld, ill, msk, pd, sr};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic step(input logic [2:0] c, input logic [1:0] b, input logic k);
    @(negedge clk);
    cmd = c; ba = b; cke = k;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd = 3'd0; ba = 2'd0; cke = 1'b1; four_bank = 1'b1;
    #1 check("R1 ", 5'b00000);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1 check("R1 ", 5'b00000);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    do_reset();

    for (int i = 0; i < 34; i++) begin
      step(VECS[i].c, VECS[i].b, VECS[i].k);
      check(VECS[i].tag, VECS[i].exp);
    end

    // R1: banks idle after reset
    do_reset();
    step(3'd1, 2'd2, 1'b1);
    check("R1 ", 5'b10000);
    // R14: upper bank left open, two-bank mode ignores it
    four_bank = 1'b0;
    step(3'd0, 2'd0, 1'b0);
    check("R14", 5'b00010);
    step(3'd0, 2'd0, 1'b1);
    check("R14", 5'b00000);
    step(3'd1, 2'd3, 1'b1);
    check("R14", 5'b11000);
    step(3'd1, 2'd1, 1'b1);
    check("R14", 5'b10000);
    // R12: cke low with an open bank: command illegal, no power down
    step(3'd2, 2'd1, 1'b0);
    check("R12", 5'b11000);
    step(3'd0, 2'd0, 1'b1);
    check("R11", 5'b00000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule